// File: doc/BRIEF.md
# Transaction Atomicity Race Checker

This block watches a stream of observation events and checks that read-modify-write sequences on a shared resource are not interleaved. Two event codes matter. One says that a source has entered the read half of a sequence, so a transaction opens. The other says that a source has returned from the write half, so the transaction ends. Every event names the source that raised it. The checker remembers whether a transaction is open and which source owns it. When a different source opens or ends a transaction while one is still open, the checker emits a race event on its output stream.

Both streams are valid/ready. An input event is taken on a clock edge where `in_valid` and `in_ready` are both high. A race event stays in a one-entry output slot until the edge where `out_valid` and `out_ready` are both high. The input is held off only while that slot is full and the consumer is not ready. Events with any other code pass through the checker, are consumed and have no effect. A saturating count of detected races is always visible on a plain status output.

Top module: `atom_race_chk`

## Requirements
- R1: After reset no transaction is open, `race_count` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: An open event (type 0x0011) accepted while no transaction is open opens one and records its source as owner. Further open events from the owner raise no race.
- R3: A close event (type 0x0012) from the owner ends the open transaction without a race.
- R4: An open event from a source other than the owner, while a transaction is open, raises a race. That source becomes the owner and the transaction stays open.
- R5: A close event from a source other than the owner, while a transaction is open, raises a race and ends the transaction.
- R6: A close event accepted while no transaction is open is ignored: there is no race and no state change.
- R7: Events of any other type are accepted and dropped. This holds for any source, and they raise no race and change no state.
- R8: A race event appears on the output in the cycle after the offending input is accepted. Its `out_type` is 0x00E0 and its `out_src` carries the checker's own identifier (parameter, default 0). It has no payload.
- R9: `in_ready` is low only while a race event is waiting and `out_ready` is low. A waiting race event holds its value until it is taken.
- R10: `race_count` rises by one for each detected race, one cycle after the offending input is accepted, and stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Checker can take an input event |
| in_type | input | 16 | Input event code |
| in_src | input | SRC_W | Source that raised the input event |
| out_valid | output | 1 | Race event present |
| out_ready | input | 1 | Consumer takes the race event |
| out_type | output | 16 | Output event code (race) |
| out_src | output | SRC_W | Checker identifier |
| race_count | output | CNT_W | Saturating count of races |

## Verification
The assertions assume that the producer keeps an event stable while it waits for `in_ready`. They also assume that open and close events are the only codes that touch the owner state. The bench drives each event at a fixed offset after the falling edge. It holds the event until an edge where `in_ready` is high, and it changes `out_ready` only at that same offset. It checks back-pressure by holding `out_ready` low with a race event waiting and a new input event offered. The counter is built narrow in the bench so that saturation can be reached.

// File: rtl/atom_race_pkg.sv
package atom_race_pkg;
  typedef enum logic [1:0] {
    EV_OTHER = 2'd0,
    EV_OPEN  = 2'd1,
    EV_CLOSE = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/arc_classify.sv
module arc_classify
  import atom_race_pkg::*;
#(
  parameter int          TYPE_W     = 16,
  parameter logic [15:0] CODE_OPEN  = 16'h0011,
  parameter logic [15:0] CODE_CLOSE = 16'h0012
) (
  input  logic [TYPE_W-1:0] ev_type,
  output ev_kind_t          kind
);
  localparam logic [TYPE_W-1:0] OPEN_C  = TYPE_W'(CODE_OPEN);
  localparam logic [TYPE_W-1:0] CLOSE_C = TYPE_W'(CODE_CLOSE);

  always_comb begin
    if (ev_type == OPEN_C)       kind = EV_OPEN;
    else if (ev_type == CLOSE_C) kind = EV_CLOSE;
    else                         kind = EV_OTHER;
  end
endmodule

// File: rtl/arc_owner_track.sv
module arc_owner_track
  import atom_race_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  ev_kind_t         kind,
  input  logic [SRC_W-1:0] src,
  output logic             race,
  output logic             busy
);
  logic [SRC_W-1:0] owner_q;
  logic             busy_q;
  logic             foreign;

  assign foreign = busy_q && (src != owner_q);
  assign race    = fire && (kind != EV_OTHER) && foreign;
  assign busy    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (fire) begin
      case (kind)
        EV_OPEN: begin
          busy_q  <= 1'b1;
          owner_q <= src;
        end
        EV_CLOSE: begin
          if (busy_q) busy_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R4
  owner_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (race && kind == EV_OPEN) |=> (busy_q && owner_q == $past(src)));
  // R5
  foreign_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (race && kind == EV_CLOSE) |=> !busy_q);
  // R7
  other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == EV_OTHER) |=> ($stable(busy_q) && $stable(owner_q)));
endmodule

// File: rtl/arc_race_slot.sv
module arc_race_slot #(
  parameter int          TYPE_W    = 16,
  parameter int          SRC_W     = 4,
  parameter logic [15:0] CODE_RACE = 16'h00E0,
  parameter int          SELF_ID   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [TYPE_W-1:0] out_type,
  output logic [SRC_W-1:0]  out_src,
  output logic              stall
);
  logic             full_q;
  logic [TYPE_W-1:0] type_q;

  assign stall     = full_q && !out_ready;
  assign out_valid = full_q;
  assign out_type  = type_q;
  assign out_src   = SRC_W'(SELF_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      type_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      type_q <= TYPE_W'(CODE_RACE);
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_ready) |=> (full_q && $stable(type_q)));
endmodule

// File: rtl/arc_sat_cnt.sv
module arc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != TOP)  count <= count + 1'b1;
  end

  // R10
  sat_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP) |=> (count == TOP));
  // R10
  mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/atom_race_chk.sv
module atom_race_chk
  import atom_race_pkg::*;
#(
  parameter int          SRC_W      = 4,
  parameter int          CNT_W      = 16,
  parameter logic [15:0] CODE_OPEN  = 16'h0011,
  parameter logic [15:0] CODE_CLOSE = 16'h0012,
  parameter logic [15:0] CODE_RACE  = 16'h00E0,
  parameter int          SELF_ID    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_type,
  input  logic [SRC_W-1:0] in_src,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [15:0]      out_type,
  output logic [SRC_W-1:0] out_src,
  output logic [CNT_W-1:0] race_count
);
  localparam int TYPE_W = 16;

  ev_kind_t kind;
  logic     fire, race, busy, stall;

  assign in_ready = !stall;
  assign fire     = in_valid && in_ready;

  arc_classify #(.TYPE_W(TYPE_W), .CODE_OPEN(CODE_OPEN), .CODE_CLOSE(CODE_CLOSE)) u_cls (
    .ev_type(in_type), .kind(kind)
  );

  arc_owner_track #(.SRC_W(SRC_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .fire(fire), .kind(kind), .src(in_src),
    .race(race), .busy(busy)
  );

  arc_race_slot #(.TYPE_W(TYPE_W), .SRC_W(SRC_W), .CODE_RACE(CODE_RACE), .SELF_ID(SELF_ID)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(race), .out_ready(out_ready),
    .out_valid(out_valid), .out_type(out_type), .out_src(out_src), .stall(stall)
  );

  arc_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(race), .count(race_count)
  );

  // R8
  race_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    race |=> out_valid);
  // R6
  idle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == EV_CLOSE && !busy) |=> !busy);
endmodule

// File: tb/atom_race_chk_test.sv
module atom_race_chk_test;
  localparam int SW = 4;
  localparam int CW = 4;
  localparam logic [15:0] T_OPEN  = 16'h0011;
  localparam logic [15:0] T_CLOSE = 16'h0012;
  localparam logic [15:0] T_RACE  = 16'h00E0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_type = '0;
  logic [SW-1:0] in_src = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [15:0] out_type;
  logic [SW-1:0] out_src;
  logic [CW-1:0] race_count;

  int total = 0, bad = 0, seen = 0, exp_races = 0;
  logic [15:0] last_type = '0;
  logic [SW-1:0] last_src = '1;

  always #5 clk = ~clk;

  atom_race_chk #(.SRC_W(SW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_src(in_src), .out_valid(out_valid),
    .out_ready(out_ready), .out_type(out_type), .out_src(out_src),
    .race_count(race_count)
  );

  always begin
    @(negedge clk); #3;
    if (out_valid && out_ready) begin
      seen++; last_type = out_type; last_src = out_src;
    end
  end

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic send(logic [15:0] t, int s);
    @(negedge clk); #1;
    in_valid = 1'b1; in_type = t; in_src = SW'(s);
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic int sat(int v);
    return (v > 15) ? 15 : v;
  endfunction

  task automatic t_reset;
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 race_count", int'(race_count), 0);
  endtask

  task automatic t_owner_ok;
    send(T_OPEN, 1); send(T_OPEN, 1); send(T_CLOSE, 1); idle(1);
    check("R2 R3 no race for owner", seen, exp_races);
    // closed: another source may open freely
    send(T_OPEN, 2); send(T_CLOSE, 2); idle(1);
    check("R3 closed then new owner", seen, exp_races);
  endtask

  task automatic t_open_clash;
    send(T_OPEN, 3); send(T_OPEN, 4); exp_races++; idle(1);
    check("R4 race seen", seen, exp_races);
    check("R8 race type", int'(last_type), int'(T_RACE));
    check("R8 race src", int'(last_src), 0);
    check("R10 count", int'(race_count), sat(exp_races));
    send(T_CLOSE, 4); idle(1);
    check("R4 new owner closes cleanly", seen, exp_races);
  endtask

  task automatic t_close_clash;
    send(T_OPEN, 5); send(T_CLOSE, 6); exp_races++; idle(1);
    check("R5 race seen", seen, exp_races);
    send(T_OPEN, 7); send(T_CLOSE, 7); idle(1);
    check("R5 transaction ended", seen, exp_races);
  endtask

  task automatic t_stray_close;
    send(T_CLOSE, 9); idle(1);
    check("R6 stray close ignored", seen, exp_races);
    send(T_OPEN, 8); send(T_CLOSE, 8); idle(1);
    check("R6 state unchanged", seen, exp_races);
  endtask

  task automatic t_other;
    send(T_OPEN, 1); send(16'h0042, 2); send(16'h1234, 3); idle(1);
    check("R7 other types no race", seen, exp_races);
    send(T_CLOSE, 1); idle(1);
    check("R7 owner kept", seen, exp_races);
  endtask

  task automatic t_backpressure;
    @(negedge clk); #1; out_ready = 1'b0;
    send(T_OPEN, 2); send(T_OPEN, 11); exp_races++;
    @(negedge clk); #1;
    check("R9 ready low while held", int'(in_ready), 0);
    in_valid = 1'b1; in_type = T_CLOSE; in_src = SW'(11);
    idle(3);
    check("R9 still held", int'(out_valid), 1);
    check("R9 type stable", int'(out_type), int'(T_RACE));
    check("R9 input still blocked", int'(in_ready), 0);
    check("R9 not yet taken", seen, exp_races - 1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    in_valid = 1'b0;
    idle(1);
    check("R9 taken after ready", seen, exp_races);
    // close from 11 was accepted: 12 opens with no race
    send(T_OPEN, 12); send(T_CLOSE, 12); idle(1);
    check("R9 blocked input consumed", seen, exp_races);
  endtask

  task automatic t_saturate;
    send(T_OPEN, 0);
    for (int i = 0; i < 16; i++) begin
      send(T_OPEN, (i % 2) + 1); exp_races++;
    end
    send(T_CLOSE, 2); idle(1);
    check("R10 race events", seen, exp_races);
    check("R10 saturated", int'(race_count), sat(exp_races));
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=timeout expected=done");
      end
      begin
        idle(2);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_owner_ok();
        t_open_clash();
        t_close_clash();
        t_stray_close();
        t_other();
        t_backpressure();
        check("R10 count mid", int'(race_count), sat(exp_races));
        t_saturate();
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule